// File: doc/BRIEF.md
# Simultaneous-Sample Conversion Sequencer

This block is the digital control core of a four-channel converter that samples all of its inputs at one instant and then digitises them one after another. A rising edge on the convert-start input freezes every sample/hold stage at the same time. The block then steps a single shared converter through the chosen channels, one conversion at a time. The analog converter itself is outside the block. The block tells it which channel to convert and samples its result port once a fixed number of conversion clocks has passed.

The set of channels to convert is a 4-bit mask. It is taken either from four select pins or from a small select register, and a mode input chooses between the two sources. A host writes the register over a simple parallel strobe interface. Each finished conversion produces a one-cycle active-low end-of-conversion strobe, together with the captured result and the number of its channel. A busy flag covers the whole sequence. While the standby input is low, no sequence can be started.

Top module: `simseq_seq`

## Requirements
- R1: With `standby_n` high and `busy` low, a 0-to-1 change of `conv_start` seen at a clock edge sets `busy` and all bits of `sh_hold` high after that edge. `sh_hold` stays all ones for as long as `busy` is high.
- R2: The channel mask is captured at the start edge. Changes to `sel_pins`, `hw_sw_sel` or the register after that edge have no effect on the sequence already running.
- R3: When `hw_sw_sel` is 0 the mask comes from `sel_pins`. When it is 1 the mask comes from the select register.
- R4: The register loads `bus_din` on a 0-to-1 change of `wr_n` seen while `cs_n` is 0 and `rd_n` is 1. Bit 0 selects channel 1 and bit 3 selects channel 4. A write strobe with `cs_n` high or with `rd_n` low leaves the register unchanged.
- R5: Only the channels in the mask are converted, in ascending order from channel 1 to channel 4. `conv_chan` and `adc_chan` report channel 1 as 0 and channel 4 as 3.
- R6: Each conversion lasts 14 clocks. For the j-th selected channel, `eoc_n` is low for exactly one cycle, starting 14·j edges after the start edge. In that same cycle, `conv_data` holds the `adc_result` that was present while the channel was being converted, and `conv_chan` holds that channel's number.
- R7: With k channels selected, `busy` stays high for 14·k+1 cycles. It falls at the edge after the last `eoc_n` pulse.
- R8: An all-zero mask raises `busy` for one cycle and produces no `eoc_n` pulse.
- R9: A `conv_start` rising edge that arrives while `busy` is high is ignored.
- R10: While `standby_n` is low, a `conv_start` rising edge starts nothing.
- R11: After reset, `busy` is 0, `eoc_n` is 1, `sh_hold` is 0, and the select register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Convert start; its rising edge begins a sequence |
| standby_n | input | 1 | Low blocks new sequences |
| hw_sw_sel | input | 1 | 0 selects the mask from pins, 1 from the register |
| sel_pins | input | 4 | Hardware channel mask |
| cs_n | input | 1 | Register select, active low |
| rd_n | input | 1 | Read strobe, active low; blocks writes when low |
| wr_n | input | 1 | Write strobe; its rising edge writes the register |
| bus_din | input | 4 | Register write data |
| adc_result | input | 12 | Converter result for the current channel |
| sh_hold | output | 4 | Sample/hold stages in hold |
| busy | output | 1 | Sequence in progress |
| eoc_n | output | 1 | Active-low one-cycle end-of-conversion strobe |
| adc_chan | output | 2 | Channel currently being converted |
| conv_data | output | 12 | Result captured at the last end of conversion |
| conv_chan | output | 2 | Channel of `conv_data` |

## Verification
The bench targets the following mistakes and the symptom each one would produce:
- **Selection changed mid-sequence (R2).** The bench changes `sel_pins` and flips `hw_sw_sel` partway through each sequence. A design that re-reads its source instead of latching it at the start edge would skip or add channels.
- **Empty mask (R8).** A design that mishandles it would either hang with `busy` stuck high or emit a spurious strobe.
- **Restart while busy (R9).** The bench sends a second start edge during a sequence. Honouring it would restart the count and move every later strobe away from its 14-cycle slot.
- **Blocked register writes (R4).** Writes with `cs_n` high or `rd_n` low must not load. A design that accepted them would convert the wrong channels once the register is selected.
- **Full and single-channel masks.** These expose off-by-one errors in the conversion counter and in the cycle where `busy` falls.

// File: rtl/simseq_pkg.sv
package simseq_pkg;

    localparam int SQ_NCH_DEF    = 4;
    localparam int SQ_DW_DEF     = 12;
    localparam int SQ_CONV_DEF   = 14;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_CONV = 2'd1,
        SQ_DONE = 2'd2
    } sq_state_t;

endpackage

// File: rtl/simseq_edge.sv
module simseq_edge #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= RST_VAL;
        else     prev_q <= din;
    end

    assign rise = din & ~prev_q;
endmodule

// File: rtl/simseq_selreg.sv
module simseq_selreg #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [NCH-1:0] din,
    output logic [NCH-1:0] sel_q
);
    logic wr_rise;

    simseq_edge #(.RST_VAL(1'b1)) u_wr_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (wr_n),
        .rise (wr_rise)
    );

    always_ff @(posedge clk) begin
        if (rst)                          sel_q <= '0;
        else if (wr_rise && !cs_n && rd_n) sel_q <= din;
    end
endmodule

// File: rtl/simseq_pick.sv
module simseq_pick #(
    parameter int NCH = 4,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] mask,
    output logic           found,
    output logic [IW-1:0]  idx,
    output logic [NCH-1:0] rest
);
    logic [NCH-1:0] lowest;

    // one-hot of the lowest set bit, built per bit
    for (genvar g = 0; g < NCH; g++) begin : g_low
        if (g == 0) begin : g_first
            assign lowest[g] = mask[g];
        end else begin : g_rest
            assign lowest[g] = mask[g] & ~(|mask[g-1:0]);
        end
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (lowest[i]) idx = IW'(i);
        end
    end

    assign found = |mask;
    assign rest  = mask & ~lowest;
endmodule

// File: rtl/simseq_seq.sv
module simseq_seq
    import simseq_pkg::*;
#(
    parameter int NCH         = SQ_NCH_DEF,
    parameter int DW          = SQ_DW_DEF,
    parameter int CONV_CYCLES = SQ_CONV_DEF
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   conv_start,
    input  logic                   standby_n,
    input  logic                   hw_sw_sel,
    input  logic [NCH-1:0]         sel_pins,
    input  logic                   cs_n,
    input  logic                   rd_n,
    input  logic                   wr_n,
    input  logic [NCH-1:0]         bus_din,
    input  logic [DW-1:0]          adc_result,
    output logic [NCH-1:0]         sh_hold,
    output logic                   busy,
    output logic                   eoc_n,
    output logic [$clog2(NCH)-1:0] adc_chan,
    output logic [DW-1:0]          conv_data,
    output logic [$clog2(NCH)-1:0] conv_chan
);
    localparam int IW = $clog2(NCH);
    localparam int TW = $clog2(CONV_CYCLES);
    localparam logic [TW-1:0] T_LAST = TW'(CONV_CYCLES - 1);

    sq_state_t      state;
    logic           start_rise;
    logic           go;
    logic [NCH-1:0] sw_sel;
    logic [NCH-1:0] cand_sel;
    logic [NCH-1:0] pending;
    logic [NCH-1:0] pick_in;
    logic           pick_found;
    logic [IW-1:0]  pick_idx;
    logic [NCH-1:0] pick_rest;
    logic [IW-1:0]  chan_q;
    logic [TW-1:0]  tick;
    logic           busy_q;
    logic           eoc_q;
    logic [DW-1:0]  data_q;
    logic [IW-1:0]  dchan_q;

    simseq_edge #(.RST_VAL(1'b1)) u_start_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (conv_start),
        .rise (start_rise)
    );

    simseq_selreg #(.NCH(NCH)) u_selreg (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .rd_n  (rd_n),
        .wr_n  (wr_n),
        .din   (bus_din),
        .sel_q (sw_sel)
    );

    assign cand_sel = hw_sw_sel ? sw_sel : sel_pins;
    assign go       = start_rise && standby_n && (state == SQ_IDLE);
    assign pick_in  = (state == SQ_IDLE) ? cand_sel : pending;

    simseq_pick #(.NCH(NCH)) u_pick (
        .mask  (pick_in),
        .found (pick_found),
        .idx   (pick_idx),
        .rest  (pick_rest)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SQ_IDLE;
            busy_q  <= 1'b0;
            eoc_q   <= 1'b1;
            pending <= '0;
            chan_q  <= '0;
            tick    <= '0;
            data_q  <= '0;
            dchan_q <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    eoc_q <= 1'b1;
                    if (go) begin
                        busy_q <= 1'b1;
                        tick   <= '0;
                        if (pick_found) begin
                            chan_q  <= pick_idx;
                            pending <= pick_rest;
                            state   <= SQ_CONV;
                        end else begin
                            state   <= SQ_DONE;
                        end
                    end
                end
                SQ_CONV: begin
                    if (tick == T_LAST) begin
                        eoc_q   <= 1'b0;
                        data_q  <= adc_result;
                        dchan_q <= chan_q;
                        tick    <= '0;
                        if (pick_found) begin
                            chan_q  <= pick_idx;
                            pending <= pick_rest;
                        end else begin
                            state   <= SQ_DONE;
                        end
                    end else begin
                        eoc_q <= 1'b1;
                        tick  <= tick + 1'b1;
                    end
                end
                SQ_DONE: begin
                    busy_q <= 1'b0;
                    eoc_q  <= 1'b1;
                    state  <= SQ_IDLE;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign sh_hold   = {NCH{busy_q}};
    assign busy      = busy_q;
    assign eoc_n     = eoc_q;
    assign adc_chan  = chan_q;
    assign conv_data = data_q;
    assign conv_chan = dchan_q;
endmodule

// File: rtl/simseq_chk.sv
module simseq_chk #(
    parameter int NCH         = 4,
    parameter int DW          = 12,
    parameter int CONV_CYCLES = 14
) (
    input logic           clk,
    input logic           rst,
    input logic           conv_start,
    input logic           standby_n,
    input logic           busy,
    input logic           eoc_n,
    input logic [NCH-1:0] sh_hold,
    input logic [DW-1:0]  conv_data
);
    logic [15:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !busy)        run_cnt <= '0;
        else if (run_cnt != '1)  run_cnt <= run_cnt + 1'b1;
    end

    // R1
    start_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ($past(conv_start) && $past(standby_n)));

    // R1
    hold_all_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (sh_hold == {NCH{1'b1}}));

    // R6
    eoc_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        !eoc_n |-> busy);

    // R6
    eoc_width_chk: assert property (@(posedge clk) disable iff (rst)
        !eoc_n |=> eoc_n);

    // R6
    eoc_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        !eoc_n |-> ((run_cnt != 16'd0) && ((run_cnt % CONV_CYCLES) == 0)));

    // R6
    data_update_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(conv_data) |-> !eoc_n);

    // R10
    standby_chk: assert property (@(posedge clk) disable iff (rst)
        (!standby_n && !busy) |=> !busy);
endmodule

bind simseq_seq simseq_chk #(
    .NCH         (NCH),
    .DW          (DW),
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .conv_start (conv_start),
    .standby_n  (standby_n),
    .busy       (busy),
    .eoc_n      (eoc_n),
    .sh_hold    (sh_hold),
    .conv_data  (conv_data)
);

// File: tb/tb_simseq_seq.sv
`timescale 1ns/1ps
module tb_simseq_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_start = 1'b0;
    logic        standby_n = 1'b1;
    logic        hw_sw_sel = 1'b0;
    logic [3:0]  sel_pins = 4'h0;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [3:0]  bus_din = 4'h0;
    logic [11:0] adc_result;
    logic [3:0]  sh_hold;
    logic        busy;
    logic        eoc_n;
    logic [1:0]  adc_chan;
    logic [11:0] conv_data;
    logic [1:0]  conv_chan;

    int checks = 0;
    int errors = 0;
    logic [3:0] reg_model = 4'h0;

    always #5 clk = ~clk;

    function automatic logic [11:0] exp_data(input int ch);
        return 12'h3A0 + 12'(ch) * 12'h041;
    endfunction

    // converter model: result depends on the channel being converted
    assign adc_result = exp_data(int'(adc_chan));

    simseq_seq dut (
        .clk(clk), .rst(rst), .conv_start(conv_start), .standby_n(standby_n),
        .hw_sw_sel(hw_sw_sel), .sel_pins(sel_pins), .cs_n(cs_n), .rd_n(rd_n),
        .wr_n(wr_n), .bus_din(bus_din), .adc_result(adc_result),
        .sh_hold(sh_hold), .busy(busy), .eoc_n(eoc_n), .adc_chan(adc_chan),
        .conv_data(conv_data), .conv_chan(conv_chan)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic write_reg(input logic [3:0] val, input logic cs_lvl, input logic rd_lvl);
        @(negedge clk);
        cs_n = cs_lvl; rd_n = rd_lvl; bus_din = val; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
        if (!cs_lvl && rd_lvl) reg_model = val;   // R4
    endtask

    task automatic run_seq(input logic mode, input logic [3:0] pins, input logic interfere);
        logic [3:0] sel;
        int order[4];
        int k;
        int j;
        logic exp_busy;
        logic exp_eoc;
        sel = mode ? reg_model : pins;             // R3
        k = 0;
        for (int c = 0; c < 4; c++) begin
            order[c] = 0;
            if (sel[c]) begin order[k] = c; k++; end
        end
        hw_sw_sel = mode;
        sel_pins  = pins;
        @(negedge clk);
        conv_start = 1'b1;
        j = 0;
        for (int n = 0; n <= 14 * k + 2; n++) begin
            @(negedge clk);
            if (n == 0) conv_start = 1'b0;
            if (n == 2) begin                      // R2: source changes after capture
                sel_pins  = ~pins;
                hw_sw_sel = ~mode;
            end
            if (interfere && k > 0 && n == 5) conv_start = 1'b1;   // R9
            if (interfere && k > 0 && n == 6) conv_start = 1'b0;
            exp_busy = (n <= 14 * k);
            exp_eoc  = !(n > 0 && (n % 14) == 0 && n <= 14 * k);
            chk(busy == exp_busy, (k == 0) ? "R8 busy" : (interfere ? "R9 busy" : "R7 busy"),
                int'(busy), int'(exp_busy));
            chk(eoc_n == exp_eoc, (k == 0) ? "R8 eoc_n" : "R6 eoc_n", int'(eoc_n), int'(exp_eoc));
            chk(sh_hold == {4{exp_busy}}, "R1 sh_hold", int'(sh_hold), exp_busy ? 15 : 0);
            if (!exp_eoc && j < k) begin
                chk(int'(conv_chan) == order[j], "R5 conv_chan", int'(conv_chan), order[j]);
                chk(conv_data == exp_data(order[j]), "R6 conv_data",
                    int'(conv_data), int'(exp_data(order[j])));
                j++;
            end
        end
        chk(j == k, "R2 count", j, k);
        hw_sw_sel = mode;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk(busy == 1'b0, "R11 busy", int'(busy), 0);
        chk(eoc_n == 1'b1, "R11 eoc_n", int'(eoc_n), 1);
        chk(sh_hold == 4'h0, "R11 sh_hold", int'(sh_hold), 0);
        // R11 register cleared: selecting it converts nothing
        run_seq(1'b1, 4'hF, 1'b0);

        // directed: full mask, single channels, empty mask from pins
        run_seq(1'b0, 4'hF, 1'b0);
        run_seq(1'b0, 4'h8, 1'b0);
        run_seq(1'b0, 4'h1, 1'b0);
        run_seq(1'b0, 4'h0, 1'b0);                 // R8
        run_seq(1'b0, 4'hA, 1'b1);                 // R9

        // R3/R4 register source
        write_reg(4'h6, 1'b0, 1'b1);
        run_seq(1'b1, 4'h9, 1'b0);
        write_reg(4'h9, 1'b1, 1'b1);               // R4 ignored: cs_n high
        write_reg(4'hF, 1'b0, 1'b0);               // R4 ignored: rd_n low
        run_seq(1'b1, 4'h1, 1'b0);                 // R4 expects mask 6

        // R10 standby blocks starts
        standby_n = 1'b0;
        @(negedge clk); conv_start = 1'b1;
        @(negedge clk); conv_start = 1'b0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            chk(busy == 1'b0, "R10 busy", int'(busy), 0);
            chk(eoc_n == 1'b1, "R10 eoc_n", int'(eoc_n), 1);
        end
        standby_n = 1'b1;
        @(negedge clk);

        // random mix
        for (int r = 0; r < 16; r++) begin
            if ($urandom % 3 == 0) write_reg(4'($urandom), 1'($urandom), 1'($urandom));
            run_seq(1'($urandom), 4'($urandom), 1'($urandom));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule